// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor whose procedures each see their own window of a larger physical array. An instruction names one of 32 architectural registers. The block combines that name with a current-window pointer and picks one physical register. Eight globals are the same in every window. Each window has eight private locals. Each window also has eight "in" registers that it shares with the neighbouring window, which sees them as its "out" registers. Because of this overlap, arguments pass between caller and callee without being copied.

There are two combinational read ports and one write port that writes on the clock edge. A save request moves to a fresh window and a restore request moves back. A trap request also moves to a fresh window, and in the same edge it writes the supplied program counter and next program counter into locals of that new window. A per-window invalid mask guards the moves. A move into a masked window is refused and a trap flag is raised, so that outside logic can spill or fill the window.

Top module: `wreg_file`

## Requirements
- R1: Architectural indices 0–7 select eight global registers. These map to the same storage whatever the window pointer holds, so a value written to a global in one window reads back unchanged in any other window.
- R2: Index 0 always reads as zero on both read ports, and a write to index 0 has no effect.
- R3: An accepted save lowers the window pointer by one and an accepted restore raises it by one, both modulo NWIN (for example 0 −1 gives NWIN−1 and NWIN−1 +1 gives 0). The pointer changes on the clock edge that samples the request, and `cwp_o` shows it.
- R4: Indices 8–15 are the outs and 24–31 are the ins. Out k of window w is the same storage as in k of window w−1. A value written as out k before a save therefore reads as in k (index 24+k) after it.
- R5: Indices 16–23 are locals, private to each window. A local written in one window is not visible as the same local in an adjacent window.
- R6: An accepted trap lowers the pointer exactly as a save does. On the same edge it writes `trap_pc` into local 1 (index 17) and `trap_npc` into local 2 (index 18) of the newly selected window.
- R7: When a save or trap would enter a window whose mask bit is set, `overflow_o` is high in that cycle. The pointer does not move and the trap does not write its locals. An ordinary write in that cycle still takes place.
- R8: When a restore would enter a window whose mask bit is set, `underflow_o` is high in that cycle and the pointer is left unchanged.
- R9: If a read addresses the same physical register that is being written in that cycle, the read returns the value held before the write.
- R10: After reset the pointer is 0, the invalid mask is clear and every register reads zero.
- R11: If several requests arrive together, trap takes precedence over save, and save over restore. An ordinary write in the same cycle uses the window that was current before the move. A mask write replaces the whole mask on the edge and is first used in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A architectural index |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | 5 | Read port B architectural index |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write architectural index |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Move to the next lower window |
| restore_req | input | 1 | Move to the next higher window |
| trap_req | input | 1 | Trap entry: move down and record PCs |
| trap_pc | input | XLEN | Program counter stored on trap |
| trap_npc | input | XLEN | Next program counter stored on trap |
| mask_wr_en | input | 1 | Load the invalid-window mask |
| mask_wr_data | input | NWIN | New invalid-window mask |
| cwp_o | output | CW | Current window pointer |
| overflow_o | output | 1 | Save/trap refused by the mask |
| underflow_o | output | 1 | Restore refused by the mask |

## Verification
Two kinds of events can land in one cycle. A window move (save, restore or trap) can coincide with an ordinary write, and a write can coincide with a read of the same register. The bench provokes these directly: it writes an out register in the cycle of a save, and it reads back a register in the cycle it is written. It also runs a long random stream in which moves, writes, mask loads and reads overlap freely. A behavioural model keeps globals, locals and ins as separate per-window arrays and updates them at each edge. Every cycle it is compared on both read ports, the pointer and both flags.

// File: rtl/wreg_file.sv
module wreg_file #(
  parameter int XLEN = 32,
  parameter int NWIN = 8,
  localparam int NPHYS = 8 + 16 * NWIN,
  localparam int PW = $clog2(NPHYS),
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [4:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            trap_req,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [XLEN-1:0] trap_npc,
  input  logic            mask_wr_en,
  input  logic [NWIN-1:0] mask_wr_data,
  output logic [CW-1:0]   cwp_o,
  output logic            overflow_o,
  output logic            underflow_o
);

  logic [XLEN-1:0] rf [NPHYS];
  logic [CW-1:0]   cwp, cwp_dn, cwp_up;
  logic [NWIN-1:0] mask;

  function automatic logic [PW-1:0] phys(input logic [4:0] idx, input logic [CW-1:0] w);
    int wi, below, r;
    wi = int'(w);
    below = (wi == 0) ? NWIN - 1 : wi - 1;
    case (idx[4:3])
      2'd0:    r = int'(idx[2:0]);
      2'd1:    r = 16 + 16 * below + int'(idx[2:0]);
      2'd2:    r = 8 + 16 * wi + int'(idx[2:0]);
      default: r = 16 + 16 * wi + int'(idx[2:0]);
    endcase
    return PW'(r);
  endfunction

  assign cwp_dn = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
  assign cwp_up = (int'(cwp) == NWIN - 1) ? '0 : cwp + 1'b1;

  logic go_dn, go_up, trap_go;
  assign overflow_o  = (trap_req | save_req) & mask[cwp_dn];
  assign go_dn       = (trap_req | save_req) & ~mask[cwp_dn];
  assign underflow_o = restore_req & ~trap_req & ~save_req & mask[cwp_up];
  assign go_up       = restore_req & ~trap_req & ~save_req & ~mask[cwp_up];
  assign trap_go     = trap_req & ~mask[cwp_dn];

  assign rd_a_data = (rd_a_idx == 5'd0) ? '0 : rf[phys(rd_a_idx, cwp)];
  assign rd_b_data = (rd_b_idx == 5'd0) ? '0 : rf[phys(rd_b_idx, cwp)];
  assign cwp_o = cwp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp  <= '0;
      mask <= '0;
      for (int i = 0; i < NPHYS; i++) rf[i] <= '0;
    end else begin
      if (wr_en && wr_idx != 5'd0) rf[phys(wr_idx, cwp)] <= wr_data;
      if (trap_go) begin
        rf[phys(5'd17, cwp_dn)] <= trap_pc;
        rf[phys(5'd18, cwp_dn)] <= trap_npc;
      end
      if (go_dn) cwp <= cwp_dn;
      else if (go_up) cwp <= cwp_up;
      if (mask_wr_en) mask <= mask_wr_data;
    end
  end

  a_r2_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

  a_r7_no_overflow_move: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> (cwp_o == $past(cwp_o)));

  a_r8_no_underflow_move: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> (cwp_o == $past(cwp_o)));

  a_r3_save_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !overflow_o) |=>
      (cwp_o == (($past(cwp_o) == '0) ? CW'(NWIN - 1) : $past(cwp_o) - 1'b1)));

  a_r6_trap_records_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !overflow_o) |=> (rf[phys(5'd17, cwp_o)] == $past(trap_pc)));

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow_o && underflow_o));

endmodule

// File: tb/wreg_file_bench.sv
module wreg_file_bench;
  localparam int XLEN = 32;
  localparam int NWIN = 8;
  localparam int CW = $clog2(NWIN);

  logic clk = 0, rst_n = 0;
  logic [4:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = 0, trap_pc = 0, trap_npc = 0;
  logic wr_en = 0, save_req = 0, restore_req = 0, trap_req = 0, mask_wr_en = 0;
  logic [NWIN-1:0] mask_wr_data = 0;
  logic [CW-1:0] cwp_o;
  logic overflow_o, underflow_o;

  wreg_file #(.XLEN(XLEN), .NWIN(NWIN)) u_wreg_file (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [XLEN-1:0] glob [8];
  logic [XLEN-1:0] loc  [NWIN][8];
  logic [XLEN-1:0] ins  [NWIN][8];
  int m_cwp;
  logic [NWIN-1:0] m_mask;

  function automatic logic [XLEN-1:0] mread(int idx);
    if (idx == 0) return '0;
    if (idx < 8) return glob[idx];
    if (idx < 16) return ins[(m_cwp + NWIN - 1) % NWIN][idx - 8];
    if (idx < 24) return loc[m_cwp][idx - 16];
    return ins[m_cwp][idx - 24];
  endfunction

  task automatic mwrite(int idx, int w, logic [XLEN-1:0] v);
    if (idx == 0) return;
    if (idx < 8) glob[idx] = v;
    else if (idx < 16) ins[(w + NWIN - 1) % NWIN][idx - 8] = v;
    else if (idx < 24) loc[w][idx - 16] = v;
    else ins[w][idx - 24] = v;
  endtask

  task automatic chk(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) glob[i] = 0;
    for (int w = 0; w < NWIN; w++)
      for (int i = 0; i < 8; i++) begin loc[w][i] = 0; ins[w][i] = 0; end
    m_cwp = 0;
    m_mask = 0;
  endtask

  task automatic step(string tag, int ra, int rb, bit we, int wi, logic [XLEN-1:0] wd,
                      bit sv, bit rs, bit tr, logic [XLEN-1:0] pc, logic [XLEN-1:0] npc,
                      bit mwe, logic [NWIN-1:0] md);
    int dn, up;
    bit ovf, unf, trg;
    rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    wr_en = we; wr_idx = 5'(wi); wr_data = wd;
    save_req = sv; restore_req = rs; trap_req = tr;
    trap_pc = pc; trap_npc = npc;
    mask_wr_en = mwe; mask_wr_data = md;
    dn = (m_cwp + NWIN - 1) % NWIN;
    up = (m_cwp + 1) % NWIN;
    ovf = (tr || sv) && m_mask[dn];
    unf = rs && !tr && !sv && m_mask[up];
    #1;
    chk(tag, "rd_a", rd_a_data, mread(ra));
    chk(tag, "rd_b", rd_b_data, mread(rb));
    chk(tag, "cwp", XLEN'(cwp_o), XLEN'(m_cwp));
    chk(tag, "overflow", XLEN'(overflow_o), XLEN'(ovf));
    chk(tag, "underflow", XLEN'(underflow_o), XLEN'(unf));
    @(posedge clk);
    if (we) mwrite(wi, m_cwp, wd);
    trg = tr && !ovf;
    if (trg) begin loc[dn][1] = pc; loc[dn][2] = npc; end
    if ((tr || sv) && !ovf) m_cwp = dn;
    else if (rs && !tr && !sv && !unf) m_cwp = up;
    if (mwe) m_mask = md;
    @(negedge clk);
  endtask

  task automatic rd(string tag, int ra, int rb);
    step(tag, ra, rb, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset state
    rd("R10", 3, 20);
    rd("R10", 27, 12);
    // R2: index 0 ignores writes
    step("R2", 0, 0, 1, 0, 32'h5555, 0, 0, 0, 0, 0, 0, 0);
    rd("R2", 0, 0);
    // R1: global visible after save
    step("R1", 3, 0, 1, 3, 32'h33, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 3, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    rd("R1", 3, 0);
    // R4: out written in the cycle of a save, read as in afterwards
    step("R4", 10, 0, 1, 10, 32'hA0A0, 1, 0, 0, 0, 0, 0, 0);
    rd("R4", 26, 10);
    // R5: locals private
    step("R5", 20, 0, 1, 20, 32'hBEEF, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 20, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    rd("R5", 20, 20);
    // R9: read during write returns old value
    step("R9", 21, 21, 1, 21, 32'h1234, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 21, 21, 1, 21, 32'h5678, 0, 0, 0, 0, 0, 0, 0);
    rd("R9", 21, 0);
    // R6: trap records PCs
    step("R6", 17, 18, 0, 0, 0, 0, 0, 1, 32'h400, 32'h404, 0, 0);
    rd("R6", 17, 18);
    // R3: wrap around
    for (int i = 0; i < NWIN + 2; i++) step("R3", 8, 24, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < NWIN + 2; i++) step("R3", 8, 24, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    // R7: masked save/trap refused, write still lands
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hFF);
    step("R7", 17, 5, 1, 5, 32'h77, 0, 0, 1, 32'h900, 32'h904, 0, 0);
    step("R7", 17, 5, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    // R8: masked restore refused
    step("R8", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    // R11: mask write used next cycle; priority of trap over restore
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h00);
    step("R11", 17, 0, 1, 16, 32'h66, 0, 1, 1, 32'hC00, 32'hC04, 0, 0);
    rd("R11", 17, 18);
    // R11: random mixed stream
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step("R11", int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
           bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)), $urandom(),
           r < 15, r >= 15 && r < 30, r >= 90, $urandom(), $urandom(),
           r == 50, NWIN'($urandom() & $urandom()));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule